// File: doc/BRIEF.md
# I2C Target Front End with Split 10-bit Register Pointer

This block is the bus-facing half of an I2C target whose registers sit in a 10-bit address space. The first byte after a START carries a 5-bit chip address, the top two register-pointer bits and the read/write flag. For writes, a second byte supplies the low eight pointer bits, and every byte after that is written to the register file. Reads return bytes from the current pointer. After every data byte the pointer advances by one, so a single transaction can cover a run of consecutive registers. The pointer wraps from 0x3FF to 0x000.

SCL and SDA are sampled by a faster system clock through two-flop synchronizers. SDA is driven open-drain: `sda_oe` high means the line is pulled low. The register file connects through a write strobe and a read strobe, both one cycle long, which share one address output. Read data is taken combinationally in the cycle of the read strobe.

The control is a single state machine with eight states:
- IDLE waits for a START.
- ADDR_HI shifts in the first byte.
- ADDR_LO shifts in the low pointer byte.
- WR_DATA shifts in write bytes.
- ACK_OUT holds SDA low for one ninth clock.
- RD_DATA shifts a byte out.
- RD_ACK samples the controller's acknowledge.
- IGNORE keeps off the bus until the next START or STOP.

Its transitions are:
- START from any state goes to ADDR_HI.
- STOP from any state goes to IDLE.
- ADDR_HI goes to ACK_OUT on an address hit, or to IGNORE on a miss.
- ACK_OUT goes to ADDR_LO after a write address, to RD_DATA after a read address, and to WR_DATA after ADDR_LO or WR_DATA.
- ADDR_LO and WR_DATA each go to ACK_OUT when their byte is complete.
- RD_DATA goes to RD_ACK after eight bits.
- RD_ACK goes back to RD_DATA on an acknowledge, or to IGNORE on a not-acknowledge.

Top module: `i2c_split_target`

## Requirements
- R1: Bytes are eight bits and are shifted MSB first. In the first byte, bits 7..3 are the chip address, bits 2..1 are pointer bits 9..8, and bit 0 is the direction flag (1 = read, 0 = write).
- R2: A chip address equal to binary 101 followed by `dev_sel[1:0]` is acknowledged by pulling SDA low during the ninth clock. Any other chip address, apart from the broadcast write of R3, gets no acknowledge, and the target then stays off the bus and writes nothing until the next START.
- R3: Chip address 11011 is accepted for writes. A read sent to 11011 gets no acknowledge.
- R4: In a write, the second byte sets pointer bits 7..0. Each later byte is acknowledged and produces a one-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments.
- R5: An accepted read byte loads pointer bits 9..8 from the first byte and keeps bits 7..0. Each data byte is fetched with a one-cycle `reg_re` at the current pointer, the pointer then increments, and the byte is driven MSB first.
- R6: During a read, an acknowledge from the controller starts the next byte. A not-acknowledge ends the read: SDA is released and no further `reg_re` is issued.
- R7: The pointer increments from 0x3FF to 0x000.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START returns the target to expecting a first byte. Bytes sent after a STOP, with no new START, get no acknowledge.
- R9: After reset, `sda_oe`, `reg_we` and `reg_re` are low. `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 2 | Low two bits of the independent chip address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 10 | Register pointer, valid with either strobe |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled in the reg_re cycle |

## Verification
The bench tries several first-byte patterns against the same `dev_sel`: a matching independent address, an address that differs only in the device bits, a broadcast write and a broadcast read. Together these separate the prefix decode, the device-bit decode and the direction gating of the broadcast address. Write runs that start mid-range and at 0x3FF separate plain incrementing from wrap-around. Read runs ending in acknowledge and in not-acknowledge show whether the controller's ninth bit is obeyed. A repeated START in the middle of a write, and bytes sent after a STOP, show that the framing resets the byte machine.

// File: rtl/i2c_split_pkg.sv
package i2c_split_pkg;
    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int CHIP_W = BYTE_W - HI_W - 1;
    localparam int SEL_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CHIP_W-SEL_W-1:0] CHIP_PREFIX = 3'b101;
    localparam logic [CHIP_W-1:0]       BCAST_CHIP  = 5'b11011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WR_DATA,
        ST_ACK_OUT,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    // one extra stage keeps the previous synchronized level
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[STAGES-1];
    assign scl_old = scl_pipe[STAGES];
    assign sda_now = sda_pipe[STAGES-1];
    assign sda_old = sda_pipe[STAGES];

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign bus_start = scl_now & scl_old & sda_old & ~sda_now;
    assign bus_stop  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr
    import i2c_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_load,
    input  logic [HI_W-1:0]   hi_val,
    input  logic              lo_load,
    input  logic [BYTE_W-1:0] lo_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (hi_load) begin
            ptr[ADDR_W-1 -: HI_W] <= hi_val;
        end else if (lo_load) begin
            ptr[BYTE_W-1:0] <= lo_val;
        end else if (step) begin
            ptr <= ptr + 1'b1; // natural wrap at the top of the space
        end
    end
endmodule

// File: rtl/i2c_split_fsm.sv
module i2c_split_fsm
    import i2c_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en,
    output logic              hi_load,
    output logic [HI_W-1:0]   hi_val,
    output logic              lo_load,
    output logic [BYTE_W-1:0] lo_val,
    output logic              ptr_step
);
    tgt_state_e        state, after_ack;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              rd_acked;

    logic [CHIP_W-1:0] chip_f;
    logic              rw_f, byte_done, hit, byte_end;

    assign chip_f    = sh[BYTE_W-1 -: CHIP_W];
    assign rw_f      = sh[0];
    assign byte_done = (cnt == CNT_W'(BYTE_W));
    assign byte_end  = scl_fall & byte_done;
    assign hit       = (chip_f == {CHIP_PREFIX, dev_sel}) ||
                       ((chip_f == BCAST_CHIP) && !rw_f);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            sh        <= '0;
            cnt       <= '0;
            rd_acked  <= 1'b0;
        end else if (bus_start) begin
            state <= ST_ADDR_HI;
            cnt   <= '0;
        end else if (bus_stop) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_ADDR_HI, ST_ADDR_LO, ST_WR_DATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                        if (state != ST_ADDR_HI) begin
                            state     <= ST_ACK_OUT;
                            after_ack <= ST_WR_DATA;
                        end else if (hit) begin
                            state     <= ST_ACK_OUT;
                            after_ack <= rw_f ? ST_RD_DATA : ST_ADDR_LO;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        state <= after_ack;
                        if (after_ack == ST_RD_DATA) sh <= rd_data;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            state <= ST_RD_ACK;
                            cnt   <= '0;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        rd_acked <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (rd_acked) begin
                            state <= ST_RD_DATA;
                            sh    <= rd_data;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state == ST_ACK_OUT) || ((state == ST_RD_DATA) && !sh[BYTE_W-1]);
        wr_en   = (state == ST_WR_DATA) && byte_end;
        wr_data = sh;
        rd_en   = ((state == ST_ACK_OUT) && (after_ack == ST_RD_DATA) && scl_fall) ||
                  ((state == ST_RD_ACK) && rd_acked && scl_fall);
        hi_load = (state == ST_ADDR_HI) && byte_end && hit;
        hi_val  = sh[HI_W:1];
        lo_load = (state == ST_ADDR_LO) && byte_end;
        lo_val  = sh;
        ptr_step = wr_en || rd_en;
    end
endmodule

// File: rtl/i2c_split_target.sv
module i2c_split_target
    import i2c_split_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic hi_load, lo_load, ptr_step;
    logic [HI_W-1:0]   hi_val;
    logic [BYTE_W-1:0] lo_val;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_split_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
        .bus_stop(bus_stop), .rd_data(reg_rdata), .sda_oe(sda_oe),
        .wr_en(reg_we), .wr_data(reg_wdata), .rd_en(reg_re),
        .hi_load(hi_load), .hi_val(hi_val), .lo_load(lo_load),
        .lo_val(lo_val), .ptr_step(ptr_step)
    );

    i2c_reg_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .hi_load(hi_load), .hi_val(hi_val),
        .lo_load(lo_load), .lo_val(lo_val), .step(ptr_step), .ptr(reg_addr)
    );
endmodule

// File: rtl/i2c_split_chk.sv
module i2c_split_chk
    import i2c_split_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr
);
    logic [1:0] scl_sync;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_sync <= '1;
        else        scl_sync <= {scl_sync[0], scl_i};
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !reg_we && !reg_re));

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_sync[1]);

    // R4
    write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> sda_oe);

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |=> !(reg_we || reg_re));

    // R7
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
endmodule

bind i2c_split_target i2c_split_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_split_target.sv
module sim_i2c_split_target;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [1:0] dev_sel = 2'b10;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_oe, reg_we, reg_re;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    wire        sda_bus = sda_drv & ~sda_oe;

    always #2 clk = ~clk; // 250 MHz

    i2c_split_target u0 (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_i(scl),
        .sda_i(sda_bus), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_re  = 0;
    bit done  = 0;
    logic [7:0]  mem [0:1023];
    logic [17:0] exp_wr[$];

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model of the register port, compared every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reg_re) n_re++;
            if (reg_we) begin
                if (exp_wr.size() == 0) chk("R2/R4 unexpected write", {reg_addr, reg_wdata}, 32'hFFFF_FFFF);
                else chk("R4 write addr/data", {reg_addr, reg_wdata}, exp_wr.pop_front());
            end
        end
    end

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic i_start;
        sda_drv = 1; w(5); scl = 1; w(5); sda_drv = 0; w(5); scl = 0; w(5);
    endtask

    task automatic i_stop;
        sda_drv = 0; w(5); scl = 1; w(5); sda_drv = 1; w(5);
    endtask

    task automatic i_send(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; w(5); scl = 1; w(10); scl = 0; w(5);
        end
        sda_drv = 1; w(5); scl = 1; w(5); acked = !sda_bus; w(5); scl = 0; w(5);
    endtask

    task automatic i_recv(input logic ack, output logic [7:0] b);
        sda_drv = 1;
        for (int i = 7; i >= 0; i--) begin
            w(5); scl = 1; w(5); b[i] = sda_bus; w(5); scl = 0;
        end
        w(5); sda_drv = !ack; w(5); scl = 1; w(10); scl = 0; w(5); sda_drv = 1;
    endtask

    function automatic logic [7:0] fb(input logic [4:0] chip, input logic [9:0] a, input logic rd);
        return {chip, a[9:8], rd};
    endfunction

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    localparam logic [4:0] MINE  = 5'b10110;
    localparam logic [4:0] BCAST = 5'b11011;

    initial begin
        logic ak;
        logic [7:0] rb;
        #1 rst_n = 0;
        w(4);
        rst_n = 1;
        w(2);
        chk("R9 reset sda_oe", sda_oe, 0);
        chk("R9 reset reg_we", reg_we, 0);
        chk("R9 reset reg_re", reg_re, 0);

        // R1 R2 R4: independent write of three bytes from 0x1A5
        exp_wr.push_back({10'h1A5, 8'h11});
        exp_wr.push_back({10'h1A6, 8'h22});
        exp_wr.push_back({10'h1A7, 8'h81});
        i_start;
        i_send(fb(MINE, 10'h1A5, 0), ak); chk("R2 match ack", ak, 1);
        i_send(8'hA5, ak); chk("R4 low addr ack", ak, 1);
        i_send(8'h11, ak); chk("R4 data ack", ak, 1);
        i_send(8'h22, ak); chk("R4 data ack", ak, 1);
        i_send(8'h81, ak); chk("R4 data ack", ak, 1);
        i_stop; w(10);
        chk("R4 all writes seen", exp_wr.size(), 0);

        // R5 R6 R8: set pointer, repeated start, read three bytes
        n_re = 0;
        i_start;
        i_send(fb(MINE, 10'h1A5, 0), ak);
        i_send(8'hA5, ak);
        i_start;
        i_send(fb(MINE, 10'h1A5, 1), ak); chk("R5/R8 read addr ack", ak, 1);
        i_recv(1, rb); chk("R1/R5 read byte0", rb, 8'h11);
        i_recv(1, rb); chk("R5 read byte1", rb, 8'h22);
        i_recv(0, rb); chk("R6 read byte2", rb, 8'h81);
        w(3); chk("R6 sda released after nack", sda_oe, 0);
        chk("R6 fetch count", n_re, 3);
        i_stop;

        // R2: device bits differ
        i_start;
        i_send(fb(5'b10101, 10'h000, 0), ak); chk("R2 mismatch nack", ak, 0);
        i_send(8'h00, ak); chk("R2 ignored byte", ak, 0);
        i_send(8'h5A, ak); chk("R2 ignored byte", ak, 0);
        i_stop;

        // R3: broadcast write accepted at 0x3FE
        exp_wr.push_back({10'h3FE, 8'h5A});
        exp_wr.push_back({10'h3FF, 8'hA5});
        i_start;
        i_send(fb(BCAST, 10'h3FE, 0), ak); chk("R3 broadcast write ack", ak, 1);
        i_send(8'hFE, ak);
        i_send(8'h5A, ak); chk("R3 broadcast data ack", ak, 1);
        i_send(8'hA5, ak);
        i_stop; w(10);
        chk("R3 broadcast writes seen", exp_wr.size(), 0);

        // R3: broadcast read refused
        n_re = 0;
        i_start;
        i_send(fb(BCAST, 10'h3FE, 1), ak); chk("R3 broadcast read nack", ak, 0);
        i_recv(0, rb); chk("R3 no drive after broadcast read", rb, 8'hFF);
        chk("R3 no fetch", n_re, 0);
        i_stop;

        // R7: wrap from 0x3FF
        exp_wr.push_back({10'h3FF, 8'hC3});
        exp_wr.push_back({10'h000, 8'h3C});
        i_start;
        i_send(fb(MINE, 10'h3FF, 0), ak);
        i_send(8'hFF, ak);
        i_send(8'hC3, ak);
        i_send(8'h3C, ak);
        i_stop; w(10);
        chk("R7 wrap writes seen", exp_wr.size(), 0);
        i_start;
        i_send(fb(MINE, 10'h3FF, 0), ak);
        i_send(8'hFF, ak);
        i_start;
        i_send(fb(MINE, 10'h3FF, 1), ak);
        i_recv(1, rb); chk("R7 read 0x3FF", rb, 8'hC3);
        i_recv(0, rb); chk("R7 read wrapped 0x000", rb, 8'h3C);
        i_stop;

        // R8: repeated start mid write, then bytes after stop
        exp_wr.push_back({10'h010, 8'h77});
        exp_wr.push_back({10'h220, 8'h88});
        i_start;
        i_send(fb(MINE, 10'h010, 0), ak);
        i_send(8'h10, ak);
        i_send(8'h77, ak);
        i_start;
        i_send(fb(MINE, 10'h220, 0), ak); chk("R8 first byte after Sr", ak, 1);
        i_send(8'h20, ak);
        i_send(8'h88, ak); chk("R8 data after Sr", ak, 1);
        i_stop;
        scl = 0; w(5);
        i_send(8'hD5, ak); chk("R8 byte after stop ignored", ak, 0);
        scl = 1; w(10);
        chk("R8 writes seen", exp_wr.size(), 0);

        done = 1;
        summary;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            summary;
            $finish;
        end
    end
endmodule